// File: doc/BRIEF.md
# Cascadable Column Line Capture Register

This block gathers one horizontal line of pixel data for a 384-channel column driver. A 36-bit bus delivers six 6-bit dots on every clock. Capture begins when the start input on the active side is seen high. The next 64 clocks then fill all 384 channels, either from the low channel end or from the high channel end. A direction input picks the fill order, and it also decides which of the two side pins receives the start and which one drives it. The captured line is presented in parallel to a following latch stage.

When the driver sits in a daisy chain, the block emits a one-clock start pulse on its outgoing side pin after the 64th capture clock, so the next driver begins on the very next word. After 66 clocks the block stops by itself and ignores the bus until a new start arrives. Two inversion controls can complement the low half or the high half of the bus before storage. A rising edge on the strobe input drops any capture in progress.

Top module: `lcap_line_capture`

## Requirements
- R1: The data bus carries dot j (j = 0..5) in bits [6j+5:6j], with bit 6j as the dot's LSB. One bus word is stored on each capture edge.
- R2: The active start input is start_r_i when dir_i=1 and start_l_i when dir_i=0. If that input is sampled high on a rising edge while the block is idle, the bus words on the next 64 rising edges are stored as capture cycles k = 0..63.
- R3: A start that stays high for several clocks counts only on its first high edge. A level that is still high after a run has halted does not start a new run.
- R4: Channel c (0-based) is presented on line_o[6c+5:6c]. With dir_i=1, dot j of capture cycle k goes to channel 6k+j. With dir_i=0, it goes to channel 383-(6k+j).
- R5: The outgoing start pin is start_l_o when dir_i=1 and start_r_o when dir_i=0. It is high for exactly the one clock that follows the 64th rising edge after the start edge, and low at all other times.
- R6: The outgoing side has its output enable at 1. The incoming side has its output enable at 0 and its output at 0.
- R7: The 65th and 66th edges after the start store nothing. The block is idle after the 66th edge, and a start sampled on the 67th edge is accepted.
- R8: A rising edge on strobe_i returns the block to idle. Nothing is stored on that edge or afterwards until a new start, no cascade pulse is issued for the dropped run, and the words already stored are kept.
- R9: When inv_lo_i is 1 at a capture edge, dots 0 to 2 are stored bitwise inverted. When inv_hi_i is 1, dots 3 to 5 are stored bitwise inverted. When a control is 0, its half is stored unchanged.
- R10: A synchronous active-high rst clears every stored channel to 0, returns the block to idle and drops the cascade pulse.
- R11: line_o changes only on capture edges and on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; all capture happens on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dir_i | input | 1 | 1: right-side start in, fill upward; 0: left-side start in, fill downward |
| start_r_i | input | 1 | Right-side start pin, input path |
| start_r_o | output | 1 | Right-side start pin, output path |
| start_r_oe | output | 1 | Right-side start pin output enable |
| start_l_i | input | 1 | Left-side start pin, input path |
| start_l_o | output | 1 | Left-side start pin, output path |
| start_l_oe | output | 1 | Left-side start pin output enable |
| inv_lo_i | input | 1 | Invert dots 0 to 2 while loading |
| inv_hi_i | input | 1 | Invert dots 3 to 5 while loading |
| strobe_i | input | 1 | Line strobe; its rising edge clears the capture pointer |
| data_i | input | 36 | Six 6-bit dots per clock |
| line_o | output | 2304 | Captured line, 384 channels of 6 bits |

## Verification
The hardest states to reach are those next to the end of a run. The cascade pulse has to be seen in its single clock after the 64th edge. The two trailing edges must be shown to write nothing. A start that is still held high once the run halts must not restart capture. The bench drives fresh, distinct words on those trailing edges and on 70 more clocks with the start pin held high, then compares the whole line, so any stray write or restart shows up. A strobe raised partway through a run and a reset mid-run cover the aborted paths. Back-to-back table runs raise the next start on the 67th edge, the first edge at which it may be accepted.

// File: rtl/lcap_pkg.sv
package lcap_pkg;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } phase_e;

  // channel index seen from the opposite end of the line
  function automatic int unsigned mirror_chan(input int unsigned c, input int unsigned nch);
    return nch - 1 - c;
  endfunction

endpackage

// File: rtl/lcap_seq.sv
module lcap_seq #(
  parameter  int WORDS   = 64,
  parameter  int CASC_AT = 64,
  parameter  int HALT_AT = 66,
  localparam int CW      = $clog2(HALT_AT + 1),
  localparam int IW      = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          strobe_i,
  output logic          wr_en_o,
  output logic [IW-1:0] wr_idx_o,
  output logic          casc_o
);
  import lcap_pkg::*;

  phase_e        phase;
  logic [CW-1:0] cnt;
  logic          start_q;
  logic          stb_q;
  logic          start_rise;
  logic          stb_rise;

  assign start_rise = start_i & ~start_q;
  assign stb_rise   = strobe_i & ~stb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      start_q <= 1'b0;
      stb_q   <= 1'b0;
      casc_o  <= 1'b0;
    end else begin
      start_q <= start_i;
      stb_q   <= strobe_i;
      casc_o  <= 1'b0;
      if (stb_rise) begin
        phase <= PH_IDLE;
        cnt   <= '0;
      end else if (phase == PH_IDLE) begin
        if (start_rise) begin
          phase <= PH_RUN;
          cnt   <= '0;
        end
      end else begin
        cnt <= cnt + 1'b1;
        if (cnt == CW'(CASC_AT - 1)) casc_o <= 1'b1;
        if (cnt == CW'(HALT_AT - 1)) begin
          phase <= PH_IDLE;
          cnt   <= '0;
        end
      end
    end
  end

  always_comb begin
    wr_en_o  = (phase == PH_RUN) && !stb_rise && (cnt < CW'(WORDS));
    wr_idx_o = cnt[IW-1:0];
  end

  // R5: the cascade pulse never lasts two clocks
  a_r5_single_cycle: assert property (@(posedge clk) disable iff (rst)
    casc_o |=> !casc_o);

  // R7: while the cascade pulse is out, the run is in its non-writing tail
  a_r7_tail_no_write: assert property (@(posedge clk) disable iff (rst)
    casc_o |-> !wr_en_o);

  // R8: the clock after a strobe rise writes nothing
  a_r8_strobe_stops: assert property (@(posedge clk) disable iff (rst)
    (strobe_i && !stb_q) |=> !wr_en_o);

  // R2: an accepted start leads to word 0 on the next edge unless a strobe intervenes
  a_r2_first_word: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE && start_rise && !stb_rise) |=>
      ((wr_en_o && wr_idx_o == '0) || (strobe_i && !stb_q)));

endmodule

// File: rtl/lcap_invert.sv
module lcap_invert #(
  parameter  int DOT_W = 6,
  parameter  int DOTS  = 6,
  localparam int BUS_W = DOT_W * DOTS,
  localparam int HALF  = DOTS / 2
) (
  input  logic [BUS_W-1:0] word_i,
  input  logic             inv_lo_i,
  input  logic             inv_hi_i,
  output logic [BUS_W-1:0] word_o
);
  for (genvar j = 0; j < DOTS; j++) begin : g_dot
    logic flip;
    if (j < HALF) begin : g_lo
      assign flip = inv_lo_i;
    end else begin : g_hi
      assign flip = inv_hi_i;
    end
    assign word_o[j*DOT_W +: DOT_W] = word_i[j*DOT_W +: DOT_W] ^ {DOT_W{flip}};
  end

endmodule

// File: rtl/lcap_store.sv
module lcap_store #(
  parameter  int NCH   = 384,
  parameter  int DOT_W = 6,
  parameter  int DOTS  = 6,
  localparam int BUS_W = DOT_W * DOTS,
  localparam int WORDS = NCH / DOTS,
  localparam int IW    = $clog2(WORDS),
  localparam int LW    = NCH * DOT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en_i,
  input  logic             fwd_i,
  input  logic [IW-1:0]    wr_idx_i,
  input  logic [BUS_W-1:0] word_i,
  output logic [LW-1:0]    line_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int FK = c / DOTS;
    localparam int FJ = c % DOTS;
    localparam int RC = int'(lcap_pkg::mirror_chan(c, NCH));
    localparam int RK = RC / DOTS;
    localparam int RJ = RC % DOTS;

    logic             hit;
    logic [DOT_W-1:0] val;
    logic [DOT_W-1:0] q;

    always_comb begin
      if (fwd_i) begin
        hit = (wr_idx_i == IW'(FK));
        val = word_i[FJ*DOT_W +: DOT_W];
      end else begin
        hit = (wr_idx_i == IW'(RK));
        val = word_i[RJ*DOT_W +: DOT_W];
      end
    end

    always_ff @(posedge clk) begin
      if (rst)                q <= '0;
      else if (wr_en_i && hit) q <= val;
    end

    assign line_o[c*DOT_W +: DOT_W] = q;
  end

  // R11: without a write strobe the line holds its value
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_en_i |=> $stable(line_o));

endmodule

// File: rtl/lcap_line_capture.sv
module lcap_line_capture #(
  parameter  int NCH     = 384,
  parameter  int DOT_W   = 6,
  parameter  int DOTS    = 6,
  parameter  int CASC_AT = 64,
  parameter  int HALT_AT = 66,
  localparam int BUS_W   = DOT_W * DOTS,
  localparam int WORDS   = NCH / DOTS,
  localparam int IW      = $clog2(WORDS),
  localparam int LW      = NCH * DOT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dir_i,
  input  logic             start_r_i,
  output logic             start_r_o,
  output logic             start_r_oe,
  input  logic             start_l_i,
  output logic             start_l_o,
  output logic             start_l_oe,
  input  logic             inv_lo_i,
  input  logic             inv_hi_i,
  input  logic             strobe_i,
  input  logic [BUS_W-1:0] data_i,
  output logic [LW-1:0]    line_o
);
  logic             start_sel;
  logic             wr_en;
  logic [IW-1:0]    wr_idx;
  logic             casc;
  logic [BUS_W-1:0] word_inv;

  assign start_sel = dir_i ? start_r_i : start_l_i;

  lcap_seq #(
    .WORDS  (WORDS),
    .CASC_AT(CASC_AT),
    .HALT_AT(HALT_AT)
  ) seq_i (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_sel),
    .strobe_i(strobe_i),
    .wr_en_o (wr_en),
    .wr_idx_o(wr_idx),
    .casc_o  (casc)
  );

  lcap_invert #(
    .DOT_W(DOT_W),
    .DOTS (DOTS)
  ) inv_i (
    .word_i  (data_i),
    .inv_lo_i(inv_lo_i),
    .inv_hi_i(inv_hi_i),
    .word_o  (word_inv)
  );

  lcap_store #(
    .NCH  (NCH),
    .DOT_W(DOT_W),
    .DOTS (DOTS)
  ) store_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en_i (wr_en),
    .fwd_i   (dir_i),
    .wr_idx_i(wr_idx),
    .word_i  (word_inv),
    .line_o  (line_o)
  );

  assign start_l_oe = dir_i;
  assign start_r_oe = ~dir_i;
  assign start_l_o  = dir_i & casc;
  assign start_r_o  = ~dir_i & casc;

  // R6: exactly one side drives
  a_r6_one_driver: assert property (@(posedge clk) disable iff (rst)
    start_l_oe != start_r_oe);

  // R6: an undriven side stays low
  a_r6_quiet_side: assert property (@(posedge clk) disable iff (rst)
    (!start_r_oe |-> !start_r_o) and (!start_l_oe |-> !start_l_o));

endmodule

// File: tb/lcap_line_capture_tb_top.sv
module lcap_line_capture_tb_top;

  localparam int NCH   = 384;
  localparam int DOTS  = 6;
  localparam int WORDS = 64;
  localparam int NRUNS = 6;

  // {dir, inv_lo, inv_hi, seed}
  localparam logic [34:0] RUN_TAB [NRUNS] = '{
    {1'b1, 1'b0, 1'b0, 32'd11},
    {1'b0, 1'b0, 1'b0, 32'd23},
    {1'b1, 1'b1, 1'b0, 32'd37},
    {1'b0, 1'b0, 1'b1, 32'd41},
    {1'b1, 1'b1, 1'b1, 32'd53},
    {1'b0, 1'b1, 1'b1, 32'd67}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          dir_i = 1'b1;
  logic          start_r_i = 1'b0;
  logic          start_l_i = 1'b0;
  logic          inv_lo_i = 1'b0;
  logic          inv_hi_i = 1'b0;
  logic          strobe_i = 1'b0;
  logic [35:0]   data_i = '0;
  logic          start_r_o, start_r_oe, start_l_o, start_l_oe;
  logic [2303:0] line_o;

  int n_chk  = 0;
  int n_fail = 0;
  logic [5:0] exp_ch [NCH];

  always #10 clk = ~clk;

  lcap_line_capture dut_i (
    .clk       (clk),
    .rst       (rst),
    .dir_i     (dir_i),
    .start_r_i (start_r_i),
    .start_r_o (start_r_o),
    .start_r_oe(start_r_oe),
    .start_l_i (start_l_i),
    .start_l_o (start_l_o),
    .start_l_oe(start_l_oe),
    .inv_lo_i  (inv_lo_i),
    .inv_hi_i  (inv_hi_i),
    .strobe_i  (strobe_i),
    .data_i    (data_i),
    .line_o    (line_o)
  );

  function automatic logic [35:0] gen(input int seed, input int k);
    logic [31:0] h;
    h = 32'(seed) * 32'h9E37_79B1 ^ 32'(k + 1) * 32'h85EB_CA6B;
    h = h ^ (h >> 13);
    return {h[3:0] ^ 4'(k), h};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic chk_line(input string req);
    int bad;
    bad = -1;
    n_chk++;
    for (int c = NCH - 1; c >= 0; c--)
      if (line_o[c*6 +: 6] !== exp_ch[c]) bad = c;
    if (bad >= 0) begin
      n_fail++;
      $display("FAIL %s: channel %0d actual %0h expected %0h",
               req, bad, line_o[bad*6 +: 6], exp_ch[bad]);
    end
  endtask

  // reference model of one stored word (R1, R4, R9)
  task automatic model_word(input bit d, input bit il, input bit ih, input int k, input logic [35:0] w);
    for (int j = 0; j < DOTS; j++) begin
      logic [5:0] v;
      int ch;
      v  = w[j*6 +: 6] ^ {6{(j < 3) ? il : ih}};
      ch = d ? (6*k + j) : (NCH - 1 - (6*k + j));
      exp_ch[ch] = v;
    end
  endtask

  task automatic set_start(input bit d, input bit v);
    if (d) start_r_i = v;
    else   start_l_i = v;
  endtask

  // called at a falling edge; start is sampled on the next rising edge
  task automatic run_line(input bit d, input bit il, input bit ih, input int seed, input bit hold);
    dir_i = d; inv_lo_i = il; inv_hi_i = ih;
    set_start(d, 1'b1);
    data_i = 36'hF_FFFF_FFFF;
    @(negedge clk);
    if (!hold) set_start(d, 1'b0);
    for (int k = 0; k < WORDS; k++) begin
      data_i = gen(seed, k);
      model_word(d, il, ih, k, data_i);
      if (k == WORDS - 1)
        chk("R5 pulse low before edge 64", {63'd0, d ? start_l_o : start_r_o}, 64'd0);
      @(negedge clk);
    end
    chk("R5 pulse after edge 64", {63'd0, d ? start_l_o : start_r_o}, 64'd1);
    chk("R6 incoming side quiet", {63'd0, d ? start_r_o : start_l_o}, 64'd0);
    chk("R6 output enables", {62'd0, start_l_oe, start_r_oe}, d ? 64'd2 : 64'd1);
    data_i = gen(seed + 1000, 0);
    @(negedge clk);
    chk("R5 pulse one clock", {63'd0, d ? start_l_o : start_r_o}, 64'd0);
    data_i = gen(seed + 1000, 1);
    @(negedge clk);
    chk_line("R1/R4/R9/R7 line after run");
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    int pulses;
    for (int c = 0; c < NCH; c++) exp_ch[c] = '0;

    // R10: reset state
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk_line("R10 line cleared");
    chk("R10 start outputs low", {62'd0, start_l_o, start_r_o}, 64'd0);
    chk("R6 oe with dir=1", {62'd0, start_l_oe, start_r_oe}, 64'd2);

    // table-driven runs, back to back: each new start lands on edge 67 (R7, R2)
    for (int i = 0; i < NRUNS; i++)
      run_line(RUN_TAB[i][34], RUN_TAB[i][33], RUN_TAB[i][32], int'(RUN_TAB[i][31:0]), 1'b0);

    // R3: start held high for the whole run and long after it
    run_line(1'b1, 1'b0, 1'b1, 91, 1'b1);
    pulses = 0;
    for (int t = 0; t < 70; t++) begin
      data_i = gen(500, t);
      @(negedge clk);
      pulses += int'(start_l_o);
    end
    chk("R3 held start gives no second run", 64'(pulses), 64'd0);
    chk_line("R3/R7 line kept after halt");
    start_r_i = 1'b0;
    @(negedge clk);

    // R8: strobe partway through a run
    dir_i = 1'b0; inv_lo_i = 1'b1; inv_hi_i = 1'b0;
    start_l_i = 1'b1;
    @(negedge clk);
    start_l_i = 1'b0;
    for (int k = 0; k < 10; k++) begin
      data_i = gen(77, k);
      model_word(1'b0, 1'b1, 1'b0, k, data_i);
      @(negedge clk);
    end
    strobe_i = 1'b1;
    data_i = gen(78, 0);
    pulses = 0;
    for (int t = 0; t < 70; t++) begin
      @(negedge clk);
      pulses += int'(start_r_o);
      data_i = gen(79, t);
    end
    strobe_i = 1'b0;
    chk("R8 no cascade after strobe", 64'(pulses), 64'd0);
    chk_line("R8 words before strobe kept, later ignored");

    // R8 then R2: a fresh start after the abort works
    @(negedge clk);
    run_line(1'b0, 1'b0, 1'b0, 88, 1'b0);

    // R10: reset partway through a run
    dir_i = 1'b1;
    start_r_i = 1'b1;
    @(negedge clk);
    start_r_i = 1'b0;
    for (int k = 0; k < 5; k++) begin
      data_i = gen(99, k);
      @(negedge clk);
    end
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int c = 0; c < NCH; c++) exp_ch[c] = '0;
    chk_line("R10 reset clears line");
    pulses = 0;
    for (int t = 0; t < 70; t++) begin
      data_i = gen(100, t);
      @(negedge clk);
      pulses += int'(start_l_o);
    end
    chk("R10 reset aborts run", 64'(pulses), 64'd0);
    chk_line("R10/R11 idle after reset");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule